// File: doc/BRIEF.md
# Dual-Rate LED Blink Controller

This block drives a small set of open-drain LED pins, two by default, from a compact register file. Two blink engines run side by side. Each engine has an 8-bit prescaler register that sets its period and an 8-bit duty register that sets how much of each period the LED is lit. Each pin has a 2-bit selector. The selector can hold the pin low so the LED is lit, release the pin, or make the pin follow either engine. A released pin can serve as a general-purpose input, because the levels on the pins are synchronised and can be read back through an input register.

The block steps on a timebase enable, `tick`, which is expected to pulse at 256 times the base blink rate. Each engine splits its period into 256 duty steps. Its step counter advances once for every prescaler+1 ticks. Software changes a rate by writing the prescaler, and the new value is picked up only at the next period boundary, so no period is ever cut short. A pin output `pin_oe` at 1 means the pad pulls the pin low (LED on). A 0 means the pin is released.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset, both prescalers and both duty registers read 0, the selector register reads 8'h05 (every pin released), and every `pin_oe` bit is 0.
- R2: An engine's step counter advances exactly once per prescaler+1 cycles in which `tick` is high, and it never moves while `tick` is low.
- R3: An engine's blink level is "lit" while its step count is strictly below its duty register and "dark" otherwise. A duty of 0 is therefore always dark. A duty write takes effect at once.
- R4: A new prescaler value becomes active only on the tick where the step counter wraps from 255 to 0. If the prescaler is written in that same cycle, the written value is the one loaded.
- R5: Selector code 2'b00 holds the pin driven low (`pin_oe` = 1).
- R6: Selector code 2'b01 releases the pin (`pin_oe` = 0).
- R7: Selector code 2'b10 makes `pin_oe` follow engine 0 and code 2'b11 makes it follow engine 1, with `pin_oe` = 1 while that engine is lit. Pin p uses selector bits [2p+1:2p].
- R8: Address 0 reads the pin levels in its low bits (bit p = pin p). Each level passes through two flops, so a level applied before clock edge n reads back after edge n+1.
- R9: A write to address 0 has no effect. Addresses 6 and 7 read 0. The selector register's bits above 2×pins read 0.
- R10: Addresses 1 and 2 hold prescaler and duty of engine 0, addresses 3 and 4 those of engine 1, and address 5 the selector. Each reads back what was last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one step of the prescalers |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pin_in | input | 2 | Levels sensed on the pins |
| pin_oe | output | 2 | 1 = pull the pin low (LED lit), 0 = release |

## Verification
The two functions that can coincide are a prescaler write and the period wrap of the engine that uses that prescaler. In that cycle the wrap has to load the value being written, not the stale one. The bench watches its own model of each engine. When the model shows that the next tick will wrap an engine, the bench writes a new prescaler for that engine in that very cycle, about half the time. Every later `pin_oe` sample of a pin that follows the engine then shows whether the period length that was loaded is the correct one. Duty writes, selector writes and ticks are also random, so duty changes in the middle of a period and selector switches on a step edge are judged against the same model.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  typedef enum logic [1:0] {
    SEL_LIT  = 2'b00,
    SEL_REL  = 2'b01,
    SEL_ENG0 = 2'b10,
    SEL_ENG1 = 2'b11
  } pin_sel_e;

  // lit while the step count is below the duty threshold
  function automatic logic duty_lit(input logic [15:0] step, input logic [15:0] duty);
    return step < duty;
  endfunction

  // open-drain enable for one pin from its selector and the two engine levels
  function automatic logic pin_pull(input pin_sel_e sel, input logic lit0, input logic lit1);
    case (sel)
      SEL_LIT:  return 1'b1;
      SEL_REL:  return 1'b0;
      SEL_ENG0: return lit0;
      default:  return lit1;
    endcase
  endfunction

endpackage

// File: rtl/led_pin_sync.sv
module led_pin_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      synced <= '0;
    end else begin
      meta_q <= raw;
      synced <= meta_q;
    end
  end
endmodule

// File: rtl/led_blink_engine.sv
module led_blink_engine
  import led_blink_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] psc_nxt,
  input  logic [CW-1:0] duty,
  output logic [CW-1:0] step_q,
  output logic [CW-1:0] act_q,
  output logic          wrap,
  output logic          lit
);
  logic [CW-1:0] pre_q;
  logic          adv;

  assign adv  = tick && (pre_q == act_q);
  assign wrap = adv && (step_q == {CW{1'b1}});
  assign lit  = duty_lit(16'(step_q), 16'(duty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
      act_q  <= '0;
    end else if (tick) begin
      pre_q <= adv ? '0 : pre_q + 1'b1;
      if (adv)  step_q <= step_q + 1'b1;
      if (wrap) act_q  <= psc_nxt;
    end
  end
endmodule

// File: rtl/led_blink_regs.sv
module led_blink_regs #(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int NENG  = 2,
  parameter int NPINS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic                     wr,
  input  logic [NPINS-1:0]         in_sync,
  output logic [DW-1:0]            rdata,
  output logic [NENG-1:0][DW-1:0]  psc_nxt,
  output logic [NENG-1:0][DW-1:0]  duty_q,
  output logic [2*NPINS-1:0]       sel_q
);
  localparam int SELW = 2 * NPINS;
  localparam logic [AW-1:0] SEL_ADDR = AW'(1 + 2 * NENG);

  logic [NENG-1:0][DW-1:0] psc_q;

  for (genvar e = 0; e < NENG; e++) begin : g_eng
    logic psc_hit, duty_hit;
    logic [DW-1:0] psc_r, duty_r;
    assign psc_hit  = wr && (addr == AW'(1 + 2 * e));
    assign duty_hit = wr && (addr == AW'(2 + 2 * e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        psc_r  <= '0;
        duty_r <= '0;
      end else begin
        if (psc_hit)  psc_r  <= wdata;
        if (duty_hit) duty_r <= wdata;
      end
    end
    assign psc_q[e]   = psc_r;
    assign duty_q[e]  = duty_r;
    assign psc_nxt[e] = psc_hit ? wdata : psc_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         sel_q <= {NPINS{2'b01}};
    else if (wr && (addr == SEL_ADDR))  sel_q <= wdata[SELW-1:0];
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata[NPINS-1:0] = in_sync;
    for (int e = 0; e < NENG; e++) begin
      if (addr == AW'(1 + 2 * e)) rdata = psc_q[e];
      if (addr == AW'(2 + 2 * e)) rdata = duty_q[e];
    end
    if (addr == SEL_ADDR) rdata[SELW-1:0] = sel_q;
  end
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             wr,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe
);
  localparam int NENG = 2;

  logic [NPINS-1:0]        in_sync;
  logic [NENG-1:0][DW-1:0] psc_nxt, duty_q, step_q, act_q;
  logic [NENG-1:0]         wrap, lit;
  logic [2*NPINS-1:0]      sel_q;

  led_pin_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(in_sync)
  );

  led_blink_regs #(.DW(DW), .AW(AW), .NENG(NENG), .NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr),
    .in_sync(in_sync), .rdata(rdata), .psc_nxt(psc_nxt),
    .duty_q(duty_q), .sel_q(sel_q)
  );

  for (genvar e = 0; e < NENG; e++) begin : g_eng
    led_blink_engine #(.CW(DW)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .psc_nxt(psc_nxt[e]), .duty(duty_q[e]),
      .step_q(step_q[e]), .act_q(act_q[e]),
      .wrap(wrap[e]), .lit(lit[e])
    );
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign pin_oe[p] = pin_pull(pin_sel_e'(sel_q[2*p +: 2]), lit[0], lit[1]);
  end
endmodule

// File: rtl/led_blink_chk.sv
module led_blink_chk #(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int NENG  = 2,
  parameter int NPINS = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic [AW-1:0]           addr,
  input logic [DW-1:0]           rdata,
  input logic [2*NPINS-1:0]      sel_q,
  input logic [NPINS-1:0]        pin_oe,
  input logic [NENG-1:0][DW-1:0] step_q,
  input logic [NENG-1:0][DW-1:0] act_q,
  input logic [NENG-1:0][DW-1:0] duty_q,
  input logic [NENG-1:0]         wrap,
  input logic [NENG-1:0]         lit
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    AST_PIN_LIT: assert property (@(posedge clk) disable iff (!rst_n) (sel_q[2*p +: 2] == 2'b00) |-> pin_oe[p]); // R5
    AST_PIN_REL: assert property (@(posedge clk) disable iff (!rst_n) (sel_q[2*p +: 2] == 2'b01) |-> !pin_oe[p]); // R6
    AST_PIN_ENG0: assert property (@(posedge clk) disable iff (!rst_n) (sel_q[2*p +: 2] == 2'b10) |-> (pin_oe[p] == lit[0])); // R7
    AST_PIN_ENG1: assert property (@(posedge clk) disable iff (!rst_n) (sel_q[2*p +: 2] == 2'b11) |-> (pin_oe[p] == lit[1])); // R7
  end

  for (genvar e = 0; e < NENG; e++) begin : g_eng
    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(step_q[e])); // R2
    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wrap[e] |=> $stable(act_q[e])); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) wrap[e] |=> (step_q[e] == '0)); // R4
    AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (duty_q[e] == '0) |-> !lit[e]); // R3
  end

  AST_UNUSED_RD: assert property (@(posedge clk) disable iff (!rst_n) (addr > AW'(2 * NENG + 1)) |-> (rdata == '0)); // R9
endmodule

bind led_blink_ctrl led_blink_chk #(.DW(DW), .AW(AW), .NENG(NENG), .NPINS(NPINS)) u_chk (.*);

// File: tb/tb_led_blink_ctrl.sv
module tb_led_blink_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0;
  logic [7:0] rdata;
  logic [1:0] pin_in = '0;
  logic [1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  int boundary_hits = 0;
  bit done = 1'b0;

  // bench model of the register file and engines
  logic [7:0] m_psc [2];
  logic [7:0] m_duty[2];
  logic [7:0] m_pre [2];
  logic [7:0] m_step[2];
  logic [7:0] m_act [2];
  logic [3:0] m_sel;
  logic [1:0] m_s1, m_s2;

  led_blink_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
    .wr(wr), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic eng_lit(input int e);
    return m_step[e] < m_duty[e];
  endfunction

  function automatic logic exp_pin(input int p);
    logic [1:0] s;
    s = m_sel[2*p +: 2];
    case (s)
      2'b00:   return 1'b1;
      2'b01:   return 1'b0;
      2'b10:   return eng_lit(0);
      default: return eng_lit(1);
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {6'b0, m_s2};
      3'd1: return m_psc[0];
      3'd2: return m_duty[0];
      3'd3: return m_psc[1];
      3'd4: return m_duty[1];
      3'd5: return {4'b0, m_sel};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string pin_tag(input int p);
    case (m_sel[2*p +: 2])
      2'b00:   return "R5";
      2'b01:   return "R6";
      default: return "R7 (engine timing R2 R3 R4)";
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    if (a == 3'd0) return "R8 R9";
    if (a > 3'd5)  return "R9";
    return "R10";
  endfunction

  task automatic model_reset();
    for (int e = 0; e < 2; e++) begin
      m_psc[e] = 0; m_duty[e] = 0; m_pre[e] = 0; m_step[e] = 0; m_act[e] = 0;
    end
    m_sel = 4'b0101; m_s1 = 0; m_s2 = 0;
  endtask

  // one clock edge of the model, using the inputs held across it
  task automatic model_edge();
    logic [7:0] nxt;
    for (int e = 0; e < 2; e++) begin
      nxt = (wr && addr == 3'(1 + 2*e)) ? wdata : m_psc[e];
      if (tick) begin
        if (m_pre[e] == m_act[e]) begin
          m_pre[e] = 0;
          if (m_step[e] == 8'hFF) m_act[e] = nxt;
          m_step[e] = m_step[e] + 1;
        end else begin
          m_pre[e] = m_pre[e] + 1;
        end
      end
      m_psc[e] = nxt;
      if (wr && addr == 3'(2 + 2*e)) m_duty[e] = wdata;
    end
    if (wr && addr == 3'd5) m_sel = wdata[3:0];
    m_s2 = m_s1;
    m_s1 = pin_in;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    #1;
    chk(pin_oe == 2'b00, "R1 pins released", {6'b0, pin_oe}, 8'h00);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      chk(rdata == exp_read(addr), "R1 reset readback", rdata, exp_read(addr));
    end

    for (int cyc = 0; cyc < 60000; cyc++) begin
      @(negedge clk);
      for (int p = 0; p < 2; p++)
        chk(pin_oe[p] == exp_pin(p), pin_tag(p), {7'b0, pin_oe[p]}, {7'b0, exp_pin(p)});
      tick   = ($urandom % 4) != 0;
      addr   = 3'($urandom % 8);
      wr     = ($urandom % 6) == 0;
      wdata  = 8'($urandom);
      pin_in = 2'($urandom);
      if (addr == 3'd1 || addr == 3'd3) wdata = 8'($urandom % 4);
      // same-cycle prescaler write and period wrap (R4)
      for (int e = 0; e < 2; e++) begin
        if (tick && m_pre[e] == m_act[e] && m_step[e] == 8'hFF && ($urandom % 2) == 0) begin
          addr  = 3'(1 + 2*e);
          wr    = 1'b1;
          wdata = 8'($urandom % 4);
          boundary_hits++;
        end
      end
      #1;
      chk(rdata == exp_read(addr), rd_tag(addr), rdata, exp_read(addr));
      @(posedge clk);
      model_edge();
    end
    @(negedge clk);
    wr = 1'b0;
    tick = 1'b0;
    chk(boundary_hits > 0, "R4 boundary write exercised", 8'(boundary_hits), 8'd1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule